// File: doc/BRIEF.md
# Auto-Increment SPI Flash Byte Writer

This block sits on the host side of an SPI serial flash and writes a run of consecutive bytes using the flash's auto-address-increment program mode. A single start request carries a 24-bit start address and a byte count. The data bytes arrive later on a valid/ready stream, one byte for each program transfer. The block drives chip select, serial clock and serial data out in SPI mode 0, reads the serial data line back, and ends each session with a one-cycle done pulse or error pulse.

A session opens with a write-enable frame. The first program frame carries the program opcode, three address bytes and the first data byte. Every later byte goes in a short frame that holds only the opcode and the data. Each program frame is followed by a status frame. That frame keeps chip select low and reads repeated status bytes until the busy flag clears. After the last byte the block sends a write-disable frame and then one more status frame. A run that would pass the top of the array is refused before any bus activity. A status frame that stays busy too long aborts the session.

Top module: `aai_prog_seq`

## Requirements
- R1: During and right after reset, `ce_n` is 1, `sck` is 0, and `in_ready`, `done` and `error` are 0.
- R2: Bus timing is SPI mode 0. `sck` is 0 whenever `ce_n` is 1. `si` changes only while `sck` is low. Every byte goes out MSB first. Each `sck` high phase lasts `CLK_DIV` clock cycles. `ce_n` rises only after `sck` has been low for at least one cycle.
- R3: An accepted request first sends a frame that holds the single byte 06h.
- R4: The next frame holds five bytes: AFh, then address bits 23:16, 15:8 and 7:0, then the first data byte.
- R5: Each later data byte goes in its own two-byte frame: AFh followed by the data byte.
- R6: Each program frame is followed by a status frame. That frame sends 05h and then reads status bytes while `ce_n` stays low. It closes after the first status byte whose bit 0 is 0.
- R7: After the status frame that follows the last data byte, the block sends the one-byte frame 04h and then one more status frame. It then pulses `done` for one cycle, and `done` and `error` are never high together.
- R8: A request with `byte_cnt` of 0, or with `start_addr + byte_cnt` greater than `TOP_ADDR + 1`, pulses `error` and causes no `ce_n` activity. A run that ends exactly at `TOP_ADDR` is accepted.
- R9: If `POLL_MAX` status bytes in one status frame all read busy, the block raises `ce_n`, sends no further frame and pulses `error`.
- R10: Between two frames, `ce_n` stays high for at least `CE_GAP` clock cycles.
- R11: `in_ready` is high only while the block is waiting, with `ce_n` low and `sck` low, to shift a data byte. A byte is taken in a cycle with both `in_valid` and `in_ready` high. While `in_valid` is held low, the bus stays stalled with `ce_n` low and `sck` low.
- R12: Status bits 7:1 are ignored. A status byte of FEh counts as not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | 24 | First byte address |
| byte_cnt | input | CNT_W | Number of bytes to write |
| in_data | input | 8 | Data byte stream |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block can take a data byte now |
| ce_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| si | output | 1 | Serial data toward the flash |
| so | input | 1 | Serial data from the flash |
| busy | output | 1 | A session is in progress |
| done | output | 1 | One-cycle pulse when a session completes |
| error | output | 1 | One-cycle pulse on a refused request or a poll timeout |

## Verification
A wrong frame kind, or an address pointer that slipped, shows up in the byte content of the very frame that chip select closes. The bench decodes every frame the way a flash would. A poll counter or status decode that went wrong shows up as a status frame that is too long or too short, or as an early error, within one status frame. A gap timer or shifter phase error is visible on the next chip-select fall or the next serial clock edge. A stuck handshake state shows as `in_ready` with the bus active, or as a stall that never ends before the bench timeout.

// File: rtl/aai_pkg.sv
package aai_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADR,
      ST_WAIT,
      ST_DAT,
      ST_PRD,
      ST_GAP
   } seq_state_t;

   typedef enum logic [2:0] {
      K_WREN,
      K_PROG1,
      K_PROGN,
      K_POLLB,
      K_WRDI,
      K_POLLF,
      K_END,
      K_FAIL
   } frame_kind_t;

   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_AAI   = 8'hAF;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_DUMMY = 8'h00;

   function automatic logic [7:0] frame_opcode(frame_kind_t k);
      case (k)
         K_WREN:           return OP_WREN;
         K_PROG1, K_PROGN: return OP_AAI;
         K_POLLB, K_POLLF: return OP_RDSR;
         K_WRDI:           return OP_WRDI;
         default:          return OP_DUMMY;
      endcase
   endfunction

endpackage

// File: rtl/aai_spi_engine.sv
module aai_spi_engine #(
   parameter int CLK_DIV = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx,
   input  logic       so,
   output logic       sck,
   output logic       si,
   output logic [7:0] rx,
   output logic       fin
);

   localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end

   logic       active;
   logic       tick;
   logic [2:0] bcnt;
   logic [7:0] shreg;

   // half-period divider: omitted when every clock is a phase edge
   if (CLK_DIV == 1) begin : g_nodiv
      assign tick = active;
   end else begin : g_div
      localparam logic [DW-1:0] DLAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               dcnt <= '0;
         else if (go || !active)   dcnt <= '0;
         else if (dcnt == DLAST)   dcnt <= '0;
         else                      dcnt <= dcnt + 1'b1;
      end
      assign tick = active && (dcnt == DLAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         bcnt   <= '0;
         shreg  <= '0;
         rx     <= '0;
         sck    <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            active <= 1'b1;
            shreg  <= tx;
            bcnt   <= '0;
            sck    <= 1'b0;
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[6:0], so};
            end else begin
               sck <= 1'b0;
               if (bcnt == 3'd7) begin
                  active <= 1'b0;
                  fin    <= 1'b1;
               end else begin
                  bcnt  <= bcnt + 1'b1;
                  shreg <= {shreg[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign si = active ? shreg[7] : 1'b0;

endmodule

// File: rtl/aai_range_chk.sv
module aai_range_chk #(
   parameter int ADDR_W   = 24,
   parameter int CNT_W    = 21,
   parameter int TOP_ADDR = 24'h0FFFFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cnt,
   output logic              ok
);

   localparam int W = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1;
   localparam logic [W-1:0] LIMIT = W'(TOP_ADDR + 1);

   if (TOP_ADDR < 0) begin : g_bad_top
      $error("TOP_ADDR must not be negative");
   end

   logic [W-1:0] end_excl;

   always_comb begin
      end_excl = W'(addr) + W'(cnt);
      ok       = (cnt != '0) && (end_excl <= LIMIT);
   end

endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
   import aai_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int CNT_W      = 21,
   parameter int CE_GAP     = 10,
   parameter int POLL_MAX   = 100000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [8*ADDR_BYTES-1:0] start_addr,
   input  logic [CNT_W-1:0]        byte_cnt,
   input  logic                    range_ok,
   input  logic [7:0]              in_data,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic                    eng_fin,
   input  logic [7:0]              eng_rx,
   output logic                    eng_go,
   output logic [7:0]              eng_tx,
   output logic                    ce_n,
   output logic                    busy,
   output logic                    done,
   output logic                    error
);

   localparam int ADDR_W = 8 * ADDR_BYTES;
   localparam int AIW    = $clog2(ADDR_BYTES + 1);
   localparam int PW     = $clog2(POLL_MAX + 1);
   localparam int GW     = $clog2(CE_GAP + 1);
   localparam logic [AIW-1:0]   ALAST = AIW'(ADDR_BYTES - 1);
   localparam logic [PW-1:0]    PLAST = PW'(POLL_MAX - 1);
   localparam logic [GW-1:0]    GLAST = GW'(CE_GAP - 1);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   if (ADDR_BYTES < 1) begin : g_bad_ab
      $error("ADDR_BYTES must be at least 1");
   end
   if (CE_GAP < 1) begin : g_bad_gap
      $error("CE_GAP must be at least 1");
   end
   if (POLL_MAX < 1) begin : g_bad_poll
      $error("POLL_MAX must be at least 1");
   end

   seq_state_t        state;
   frame_kind_t       kind;
   frame_kind_t       nxt;
   logic [CNT_W-1:0]  rem;
   logic [ADDR_W-1:0] addr_q;
   logic [AIW-1:0]    aidx;
   logic [PW-1:0]     pcnt;
   logic [GW-1:0]     gcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind   <= K_WREN;
         nxt    <= K_WREN;
         rem    <= '0;
         addr_q <= '0;
         aidx   <= '0;
         pcnt   <= '0;
         gcnt   <= '0;
         ce_n   <= 1'b1;
         eng_go <= 1'b0;
         eng_tx <= '0;
         done   <= 1'b0;
         error  <= 1'b0;
      end else begin
         eng_go <= 1'b0;
         done   <= 1'b0;
         error  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (range_ok) begin
                     rem    <= byte_cnt;
                     addr_q <= start_addr;
                     kind   <= K_WREN;
                     ce_n   <= 1'b0;
                     eng_go <= 1'b1;
                     eng_tx <= OP_WREN;
                     state  <= ST_CMD;
                  end else begin
                     error <= 1'b1;
                  end
               end
            end
            ST_CMD: begin
               if (eng_fin) begin
                  case (kind)
                     K_PROG1: begin
                        aidx   <= ALAST;
                        eng_go <= 1'b1;
                        eng_tx <= addr_q[ADDR_W-1 -: 8];
                        addr_q <= addr_q << 8;
                        state  <= ST_ADR;
                     end
                     K_PROGN: state <= ST_WAIT;
                     K_POLLB, K_POLLF: begin
                        pcnt   <= '0;
                        eng_go <= 1'b1;
                        eng_tx <= OP_DUMMY;
                        state  <= ST_PRD;
                     end
                     K_WREN: begin
                        ce_n  <= 1'b1;
                        nxt   <= K_PROG1;
                        gcnt  <= '0;
                        state <= ST_GAP;
                     end
                     default: begin
                        ce_n  <= 1'b1;
                        nxt   <= K_POLLF;
                        gcnt  <= '0;
                        state <= ST_GAP;
                     end
                  endcase
               end
            end
            ST_ADR: begin
               if (eng_fin) begin
                  if (aidx == '0) begin
                     state <= ST_WAIT;
                  end else begin
                     aidx   <= aidx - 1'b1;
                     eng_go <= 1'b1;
                     eng_tx <= addr_q[ADDR_W-1 -: 8];
                     addr_q <= addr_q << 8;
                  end
               end
            end
            ST_WAIT: begin
               if (in_valid) begin
                  eng_go <= 1'b1;
                  eng_tx <= in_data;
                  rem    <= rem - ONE;
                  state  <= ST_DAT;
               end
            end
            ST_DAT: begin
               if (eng_fin) begin
                  ce_n  <= 1'b1;
                  nxt   <= K_POLLB;
                  gcnt  <= '0;
                  state <= ST_GAP;
               end
            end
            ST_PRD: begin
               if (eng_fin) begin
                  if (!eng_rx[0]) begin
                     ce_n  <= 1'b1;
                     gcnt  <= '0;
                     state <= ST_GAP;
                     if (kind == K_POLLB) nxt <= (rem == '0) ? K_WRDI : K_PROGN;
                     else                 nxt <= K_END;
                  end else if (pcnt == PLAST) begin
                     ce_n  <= 1'b1;
                     gcnt  <= '0;
                     nxt   <= K_FAIL;
                     state <= ST_GAP;
                  end else begin
                     pcnt   <= pcnt + 1'b1;
                     eng_go <= 1'b1;
                     eng_tx <= OP_DUMMY;
                  end
               end
            end
            ST_GAP: begin
               if (gcnt == GLAST) begin
                  gcnt <= '0;
                  case (nxt)
                     K_END: begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                     end
                     K_FAIL: begin
                        error <= 1'b1;
                        state <= ST_IDLE;
                     end
                     default: begin
                        kind   <= nxt;
                        ce_n   <= 1'b0;
                        eng_go <= 1'b1;
                        eng_tx <= frame_opcode(nxt);
                        state  <= ST_CMD;
                     end
                  endcase
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready = (state == ST_WAIT);
   assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq #(
   parameter int CLK_DIV  = 3,
   parameter int CE_GAP   = 10,
   parameter int POLL_MAX = 100000,
   parameter int CNT_W    = 21,
   parameter int TOP_ADDR = 24'h0FFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [23:0]      start_addr,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic [7:0]       in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             ce_n,
   output logic             sck,
   output logic             si,
   input  logic             so,
   output logic             busy,
   output logic             done,
   output logic             error
);

   localparam int ADDR_BYTES = 3;
   localparam int ADDR_W     = 8 * ADDR_BYTES;

   logic       range_ok;
   logic       eng_go;
   logic       eng_fin;
   logic [7:0] eng_tx;
   logic [7:0] eng_rx;

   aai_range_chk #(
      .ADDR_W  (ADDR_W),
      .CNT_W   (CNT_W),
      .TOP_ADDR(TOP_ADDR)
   ) u_range (
      .addr(start_addr),
      .cnt (byte_cnt),
      .ok  (range_ok)
   );

   aai_seq_ctrl #(
      .ADDR_BYTES(ADDR_BYTES),
      .CNT_W     (CNT_W),
      .CE_GAP    (CE_GAP),
      .POLL_MAX  (POLL_MAX)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .start_addr(start_addr),
      .byte_cnt  (byte_cnt),
      .range_ok  (range_ok),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .eng_fin   (eng_fin),
      .eng_rx    (eng_rx),
      .eng_go    (eng_go),
      .eng_tx    (eng_tx),
      .ce_n      (ce_n),
      .busy      (busy),
      .done      (done),
      .error     (error)
   );

   aai_spi_engine #(
      .CLK_DIV(CLK_DIV)
   ) u_eng (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (eng_go),
      .tx   (eng_tx),
      .so   (so),
      .sck  (sck),
      .si   (si),
      .rx   (eng_rx),
      .fin  (eng_fin)
   );

endmodule

// File: rtl/aai_prog_seq_chk.sv
module aai_prog_seq_chk #(
   parameter int CE_GAP = 10
) (
   input logic clk,
   input logic rst_n,
   input logic ce_n,
   input logic sck,
   input logic si,
   input logic in_ready,
   input logic busy,
   input logic done,
   input logic error
);

   localparam int HW = $clog2(CE_GAP + 1) + 1;
   localparam logic [HW-1:0] GAPV = HW'(CE_GAP);

   logic [HW-1:0] hi_cnt;

   // cycles chip select has been high, saturating; reset counts as a long gap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hi_cnt <= GAPV;
      else if (!ce_n)          hi_cnt <= '0;
      else if (hi_cnt < GAPV)  hi_cnt <= hi_cnt + 1'b1;
   end

   p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> !sck);

   p_si_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(si));

   p_ce_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |-> !$past(sck));

   p_ce_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ce_n) |-> (hi_cnt >= GAPV));

   p_ready_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!ce_n && !sck));

   p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> busy);

   p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

endmodule

bind aai_prog_seq aai_prog_seq_chk #(
   .CE_GAP(CE_GAP)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .sck     (sck),
   .si      (si),
   .in_ready(in_ready),
   .busy    (busy),
   .done    (done),
   .error   (error)
);

// File: tb/aai_prog_seq_bench.sv
module aai_prog_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 2;
   localparam int GAP   = 5;
   localparam int PMAX  = 8;
   localparam int CW    = 21;
   localparam int LIMIT = 150000;

   typedef struct {
      int          len;
      logic [39:0] bytes;
      bit          poll;
      string       tag;
   } frame_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [23:0]   start_addr = '0;
   logic [CW-1:0] byte_cnt = '0;
   logic [7:0]    in_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready, ce_n, sck, si, busy, done, error;
   logic          so = 1'b0;

   int nchk = 0;
   int nfail = 0;
   int nframes = 0;
   int cycles = 0;
   frame_t exp_q[$];
   logic [7:0] dq[$];

   int         busy_polls = 0;
   logic [7:0] busy_val = 8'h03;
   logic [7:0] rdy_val = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   aai_prog_seq #(
      .CLK_DIV (DIV),
      .CE_GAP  (GAP),
      .POLL_MAX(PMAX),
      .CNT_W   (CW),
      .TOP_ADDR(24'h0FFFFF)
   ) u_aai_prog_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .byte_cnt(byte_cnt), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .ce_n(ce_n), .sck(sck), .si(si), .so(so),
      .busy(busy), .done(done), .error(error)
   );

   function automatic void chk(bit ok, string tag, string what, longint act, longint expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
      end
   endfunction

   function automatic void expf(int len, logic [39:0] b, bit poll, string tag);
      frame_t f;
      f.len = len; f.bytes = b; f.poll = poll; f.tag = tag;
      exp_q.push_back(f);
   endfunction

   function automatic logic [7:0] stat_byte(int k);
      return (k < busy_polls) ? busy_val : rdy_val;
   endfunction

   // flash-side frame decoder and status source (monitor)
   initial begin
      logic       pce, psck, in_frame, first_hi;
      logic [7:0] sh, sb;
      logic [39:0] cap;
      int         nb, bc;
      time        t_up, t_r;
      frame_t     e;
      bit         ok;
      pce = 1'b1; psck = 1'b0; in_frame = 1'b0; first_hi = 1'b0;
      sh = '0; cap = '0; nb = 0; bc = 0; t_up = 0; t_r = 0;
      forever begin
         @(sck or ce_n);
         if (ce_n !== pce) begin
            if (ce_n === 1'b0 && rst_n === 1'b1) begin
               if (nframes > 0)
                  chk(($time - t_up) >= GAP*CLK_PERIOD, "R10", "ce high time",
                      $time - t_up, GAP*CLK_PERIOD);
               in_frame = 1'b1; first_hi = 1'b1;
               nb = 0; bc = 0; cap = '0;
            end else if (ce_n === 1'b1 && in_frame) begin
               in_frame = 1'b0;
               nframes++;
               t_up = $time;
               chk(sck === 1'b0, "R2", "sck at ce rise", sck, 0);
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R9", "unexpected frame", cap, nb);
               end else begin
                  e = exp_q.pop_front();
                  if (e.poll) ok = (nb == e.len) && (cap[39:32] == 8'h05);
                  else        ok = (nb == e.len) && (cap == e.bytes);
                  chk(ok, e.tag, "frame content/len", {cap, 8'(nb)}, {e.bytes, 8'(e.len)});
               end
            end
         end else if (sck !== psck && ce_n === 1'b0) begin
            if (sck === 1'b1) begin
               t_r = $time;
               sh = {sh[6:0], si};
               bc++;
               if (bc == 8) begin
                  if (nb < 5) cap[39-8*nb -: 8] = sh;
                  nb++;
                  bc = 0;
               end
            end else begin
               if (first_hi) begin
                  chk(($time - t_r) == DIV*CLK_PERIOD, "R2", "sck high time",
                      $time - t_r, DIV*CLK_PERIOD);
                  first_hi = 1'b0;
               end
               if (nb >= 1 && cap[39:32] == 8'h05) begin
                  sb = stat_byte(nb - 1);
                  so = sb[7 - bc];
               end
            end
         end
         pce = ce_n; psck = sck;
      end
   end

   // driver: pushes expected frames, starts the run, feeds bytes
   // mode 0: normal, 1: refused request, 2: poll timeout
   task automatic run(input logic [23:0] a, input int n, input int stall, input int mode);
      int got, idx, cyc, f0;
      logic [7:0] d0;
      f0 = nframes;
      d0 = (dq.size() > 0) ? dq[0] : 8'h00;
      if (mode != 1) begin
         expf(1, {8'h06, 32'h0}, 1'b0, "R3");
         expf(5, {8'hAF, a[23:16], a[15:8], a[7:0], d0}, 1'b0, "R4");
         if (mode == 2) begin
            expf(1 + PMAX, '0, 1'b1, "R9");
         end else begin
            expf(busy_polls + 2, '0, 1'b1, "R6");
            for (int i = 1; i < n; i++) begin
               expf(2, {8'hAF, dq[i], 24'h0}, 1'b0, "R5");
               expf(busy_polls + 2, '0, 1'b1, "R6");
            end
            expf(1, {8'h04, 32'h0}, 1'b0, "R7");
            expf(busy_polls + 2, '0, 1'b1, "R7");
         end
      end
      @(negedge clk);
      start_addr = a; byte_cnt = CW'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got = 0; idx = 0; cyc = 0;
      while (got == 0 && cyc < 20000) begin
         if (done) got = 1;
         else if (error) got = 2;
         else if (in_ready) begin
            if (stall > 0 && idx == 1) begin
               repeat (stall) @(negedge clk);
               chk(ce_n === 1'b0 && sck === 1'b0 && in_ready === 1'b1, "R11",
                   "stall bus state", {ce_n, sck, in_ready}, 3'b001);
            end
            in_data = dq[idx]; in_valid = 1'b1; idx++;
            @(negedge clk);
            in_valid = 1'b0;
            chk(in_ready === 1'b0, "R11", "ready after take", in_ready, 0);
         end
         if (got == 0) begin
            @(negedge clk);
            cyc++;
         end
      end
      if (mode == 0) chk(got == 1, "R7", "outcome done", got, 1);
      else if (mode == 1) chk(got == 2, "R8", "outcome error", got, 2);
      else chk(got == 2, "R9", "outcome error", got, 2);
      repeat (GAP + 40) @(negedge clk);
      chk(exp_q.size() == 0, (mode == 2) ? "R9" : "R6", "frames left", exp_q.size(), 0);
      if (mode == 1) chk(nframes == f0, "R8", "frames on refusal", nframes - f0, 0);
      exp_q.delete();
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > LIMIT) begin
            nfail++;
            $display("FAIL R7 watchdog: got %0d cycles expected below %0d", cycles, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(ce_n === 1'b1 && sck === 1'b0, "R1", "bus in reset", {ce_n, sck}, 2'b10);
      chk(in_ready === 1'b0 && done === 1'b0 && error === 1'b0, "R1", "flags in reset",
          {in_ready, done, error}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(ce_n === 1'b1 && sck === 1'b0 && in_ready === 1'b0, "R1", "after reset",
          {ce_n, sck, in_ready}, 3'b100);

      // three bytes, two busy reads per poll, WEL-like bit set in ready status
      dq = '{8'hA5, 8'h3C, 8'hFF};
      busy_polls = 2; rdy_val = 8'h02;
      run(24'h012345, 3, 6, 0);

      // single byte at the top address, ready status FEh (R12)
      dq = '{8'h5A};
      busy_polls = 0; rdy_val = 8'hFE;
      run(24'h0FFFFF, 1, 0, 0);

      // refused requests
      dq = '{8'h00, 8'h00};
      run(24'h0FFFFF, 2, 0, 1);
      run(24'h000100, 0, 0, 1);

      // poll timeout
      dq = '{8'h11, 8'h22};
      busy_polls = PMAX + 3; rdy_val = 8'h00;
      run(24'h000200, 2, 0, 2);

      // recovery, run ending exactly at the top
      dq = '{8'hC3, 8'h3C};
      busy_polls = 1; rdy_val = 8'h00;
      run(24'h0FFFFE, 2, 0, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule